// File: doc/BRIEF.md
# Segment and Port Pin Router

This block sits between a display waveform sequencer and the output pins of a multiplexed LCD driver. It has thirty pins. The two lowest pins always carry segment drive. The other twenty-eight pins are split into seven fixed groups of four. A 3-bit threshold field sets how many of those groups keep segment drive. Every group above the threshold turns into static digital outputs.

A pin in segment use passes on the level code that the sequencer supplies for it. A pin in port use stops carrying a level code and drives a plain logic high or low. That value is read straight from the display memory byte the pin shares with its neighbour, at the bit that belongs to the current common phase. If the four bits of the nibble agree, the port output stays static. If they differ, the output follows the phase. The routing decision and the pin values are registered together, and they change only on the sequencer's phase tick. A new threshold therefore takes effect cleanly at the next phase boundary.

Top module: `lcd_pin_route`

## Requirements
- R1: Pins 0 and 1 are never in port use. `pin_port` bits 0 and 1 stay 0, and their `pin_code` follows `seg_code`.
- R2: Pin p, for p from 2 to 29, belongs to group (p-2)/4+1. With threshold k from 1 to 7, groups 1..k are segment pins (`pin_port`=0) and groups above k are port pins (`pin_port`=1). Threshold 7 makes every pin a segment pin.
- R3: Threshold 0 puts all seven groups in port use, so only pins 0 and 1 keep segment drive.
- R4: A port pin outputs level code 0 on `pin_code`. A segment pin outputs 0 on `pin_val` and its `seg_code` slice on `pin_code`.
- R5: Pin p reads memory byte p/2, which is `disp_mem[8*(p/2)+7 : 8*(p/2)]`. An even pin reads bit `com_phase` of the low nibble. An odd pin reads bit 4+`com_phase` of the high nibble.
- R6: The outputs change only at a clock edge where `tick` is 1. A threshold write (`cfg_wr`) leaves the outputs unchanged until the next tick.
- R7: Reset clears the threshold to 0 and all outputs to 0. The first tick after reset, with no write, gives the threshold-0 routing.
- R8: A port pin whose nibble bits differ follows the bit of the current phase, so its value changes from phase to phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_wr | input | 1 | Load `cfg_sel` into the threshold register |
| cfg_sel | input | 3 | New threshold value |
| tick | input | 1 | Phase boundary strobe from the sequencer |
| com_phase | input | 2 | Current common phase, 0 to 3 |
| disp_mem | input | 120 | Display memory, 15 bytes; byte b at [8b+7:8b] |
| seg_code | input | 60 | Sequencer level code per pin, 2 bits each, pin p at [2p+1:2p] |
| pin_port | output | 30 | 1 where the pin is in port use |
| pin_val | output | 30 | Digital level of each port pin |
| pin_code | output | 60 | Level code per pin, 0 for port pins |

## Verification
Two situations are hard to reach from the ports. The first is a port pin that toggles: it appears only when a nibble holds mixed bits and the same routing is ticked across several phases. The bench keeps the threshold fixed, loads nibbles with a distinct pattern for even and odd pins, and steps `com_phase` through all four values. The second is the delayed take-over of a new threshold: the bench writes the field without a tick, checks that the outputs still show the old routing, and ticks only afterwards. Thresholds 0 and 7 are the two extremes of the group decode, and each gets its own tick.

// File: rtl/lcd_pin_route.sv
module lcd_pin_route #(
  parameter int LEAD    = 2,
  parameter int NGROUPS = 7,
  parameter int GSIZE   = 4,
  parameter int CW      = 2,
  parameter int PHW     = 2,
  localparam int SELW   = $clog2(NGROUPS + 1),
  localparam int NPINS  = LEAD + NGROUPS * GSIZE,
  localparam int NIB    = 1 << PHW,
  localparam int NBYTES = NPINS / 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_wr,
  input  logic [SELW-1:0]       cfg_sel,
  input  logic                  tick,
  input  logic [PHW-1:0]        com_phase,
  input  logic [NBYTES*2*NIB-1:0] disp_mem,
  input  logic [NPINS*CW-1:0]   seg_code,
  output logic [NPINS-1:0]      pin_port,
  output logic [NPINS-1:0]      pin_val,
  output logic [NPINS*CW-1:0]   pin_code
);

  logic [SELW-1:0]     sel_q;
  logic [NPINS-1:0]    port_d;
  logic [NPINS-1:0]    val_d;
  logic [NPINS*CW-1:0] code_d;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      sel_q <= '0;
    else if (cfg_wr) sel_q <= cfg_sel;

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    localparam int BASE = (p / 2) * 2 * NIB + (p % 2) * NIB;
    if (p < LEAD) begin : g_lead
      assign port_d[p] = 1'b0;
    end else begin : g_grp
      localparam int GRP = (p - LEAD) / GSIZE + 1;
      assign port_d[p] = (int'(sel_q) < GRP);
    end
    assign val_d[p] = port_d[p] & disp_mem[BASE + int'(com_phase)];
    assign code_d[p*CW +: CW] = port_d[p] ? '0 : seg_code[p*CW +: CW];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pin_port <= '0;
      pin_val  <= '0;
      pin_code <= '0;
    end else if (tick) begin
      pin_port <= port_d;
      pin_val  <= val_d;
      pin_code <= code_d;
    end

endmodule

module lcd_pin_route_chk #(
  parameter int LEAD    = 2,
  parameter int NGROUPS = 7,
  parameter int GSIZE   = 4,
  parameter int CW      = 2,
  localparam int SELW   = $clog2(NGROUPS + 1),
  localparam int NPINS  = LEAD + NGROUPS * GSIZE
) (
  input logic                clk,
  input logic                rst_n,
  input logic                tick,
  input logic [SELW-1:0]     sel_q,
  input logic [NPINS-1:0]    pin_port,
  input logic [NPINS-1:0]    pin_val,
  input logic [NPINS*CW-1:0] pin_code
);

  AST_LEAD_SEGMENT: assert property (@(posedge clk) disable iff (!rst_n)
    pin_port[LEAD-1:0] == '0); // R1

  AST_HOLD_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(pin_port) && $stable(pin_val) && $stable(pin_code))); // R6

  AST_FULL_SEGMENT: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && int'(sel_q) == NGROUPS) |=> pin_port == '0); // R2

  AST_FIELD_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> sel_q == '0); // R7

  for (genvar p = LEAD; p < NPINS; p++) begin : g_chk
    AST_PORT_NO_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      pin_port[p] |-> pin_code[p*CW +: CW] == '0); // R4
    AST_SEGMENT_NO_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      !pin_port[p] |-> !pin_val[p]); // R4
    if (p < NPINS - 1) begin : g_contig
      AST_PORT_CONTIGUOUS: assert property (@(posedge clk) disable iff (!rst_n)
        pin_port[p] |-> pin_port[p+1]); // R2
    end
  end

endmodule

bind lcd_pin_route lcd_pin_route_chk #(
  .LEAD(LEAD), .NGROUPS(NGROUPS), .GSIZE(GSIZE), .CW(CW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .sel_q(sel_q),
  .pin_port(pin_port), .pin_val(pin_val), .pin_code(pin_code)
);

// File: tb/lcd_pin_route_test.sv
module lcd_pin_route_test;
  localparam int NP = 30;
  localparam int NB = 15;

  typedef struct {
    logic [NP-1:0]   port;
    logic [NP-1:0]   val;
    logic [NP*2-1:0] code;
    string           tag;
  } exp_t;

  logic clk = 0, rst_n = 0, cfg_wr = 0, tick = 0;
  logic [2:0] cfg_sel = 0;
  logic [1:0] com_phase = 0;
  logic [NB*8-1:0] disp_mem = '0;
  logic [NP*2-1:0] seg_code = '0;
  logic [NP-1:0] pin_port, pin_val;
  logic [NP*2-1:0] pin_code;

  int checks = 0, fails = 0, cur_sel = 0;
  bit done = 0;
  exp_t q[$];
  exp_t last;

  always #5 clk = ~clk;

  lcd_pin_route uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .tick(tick),
    .com_phase(com_phase), .disp_mem(disp_mem), .seg_code(seg_code),
    .pin_port(pin_port), .pin_val(pin_val), .pin_code(pin_code)
  );

  function automatic exp_t model(int sel, logic [NB*8-1:0] mem,
                                 logic [NP*2-1:0] seg, int ph, string tag);
    exp_t e;
    e.tag = tag;
    for (int p = 0; p < NP; p++) begin
      e.port[p] = (p >= 2) && (sel < (p - 2) / 4 + 1);
      e.val[p]  = e.port[p] & mem[(p / 2) * 8 + (p % 2) * 4 + ph];
      e.code[p*2 +: 2] = e.port[p] ? 2'b00 : seg[p*2 +: 2];
    end
    return e;
  endfunction

  task automatic do_tick(int ph, logic [NB*8-1:0] mem, logic [NP*2-1:0] seg, string tag);
    @(negedge clk);
    com_phase = ph[1:0]; disp_mem = mem; seg_code = seg; tick = 1;
    @(negedge clk);
    tick = 0;
    last = model(cur_sel, mem, seg, ph, tag);
    q.push_back(last);
  endtask

  task automatic write_sel(int v, string tag);
    @(negedge clk);
    cfg_wr = 1; cfg_sel = v[2:0];
    com_phase = com_phase + 2'd1; disp_mem = ~disp_mem; seg_code = ~seg_code;
    @(negedge clk);
    cfg_wr = 0;
    cur_sel = v;
    last.tag = tag;
    q.push_back(last);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk);
      #3;
      if (q.size() > 0) begin
        e = q.pop_front();
        checks++;
        if (pin_port !== e.port || pin_val !== e.val || pin_code !== e.code) begin
          fails++;
          $display("FAIL %s port=%h/%h val=%h/%h code=%h/%h (actual/expected)",
                   e.tag, pin_port, e.port, pin_val, e.val, pin_code, e.code);
        end
      end
    end
  end

  initial begin : watchdog
    #2000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : driver
    logic [NB*8-1:0] mix;
    logic [NP*2-1:0] seg_a, seg_b;
    for (int b = 0; b < NB; b++) mix[b*8 +: 8] = 8'h5A ^ 8'(b * 8'h11);
    for (int p = 0; p < NP; p++) begin
      seg_a[p*2 +: 2] = 2'(p % 4);
      seg_b[p*2 +: 2] = 2'(3 - (p % 3));
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    last = model(0, '0, '0, 0, "R7 reset");
    last.port = '0;
    q.push_back(last);
    @(negedge clk);
    // R7 and R3: threshold 0 after reset
    do_tick(0, {NB{8'hF0}}, seg_a, "R7 R3 first tick");
    // R2: every threshold from 1 to 7, with R6 delayed take-over
    for (int k = 1; k <= 7; k++) begin
      write_sel(k, "R6 hold after write");
      do_tick(k % 4, (k % 2) ? mix : {NB{8'h0F}}, (k % 2) ? seg_a : seg_b, "R2 group split");
    end
    // R1: lead pins under threshold 7
    do_tick(3, mix, seg_b, "R1 lead pins");
    // R3 again and R5 even/odd nibble selection per phase, R8 toggling
    write_sel(0, "R6 hold after write 0");
    for (int ph = 0; ph < 4; ph++)
      do_tick(ph, {NB{8'b1010_0110}}, seg_a, "R5 R8 phase sweep");
    // R4: port pins with all ones memory, mid threshold
    write_sel(3, "R6 hold after write 3");
    do_tick(1, {NB{8'hFF}}, {NP{2'b11}}, "R4 port levels");
    do_tick(2, '0, seg_b, "R4 port low");
    // R6: no tick, inputs change
    @(negedge clk);
    disp_mem = mix; seg_code = seg_b; com_phase = 2'd0;
    @(negedge clk);
    last.tag = "R6 no tick";
    q.push_back(last);
    repeat (4) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule